// File: doc/BRIEF.md
# Load/Store Exclusive Monitor

This block is the per-core reservation tracker behind a load-exclusive / store-exclusive pair. A load-exclusive records the word address it touched as a tag and arms a reservation flag. From then on the monitor watches two sources of stores. The first is the owning core's own ordinary stores. The second is one or more snooped store buses that carry the stores of other cores. Any store that lands in the tagged word disarms the flag.

A store-exclusive is decided in the same cycle it is presented. It takes the target address as base plus offset. If the flag is armed, the target word equals the tag and no competing store to that word arrives in the same cycle, the monitor raises the memory write enable and forwards the address and data. It then reports status 1. Otherwise there is no write and the status is 0. The flag is dropped after every store-exclusive, whether it passed or failed. The monitor also returns the status to the core as a registered response one cycle later.

The monitor never stalls and never drains earlier accesses. A load-exclusive has no ordering side effect. Barriers, caches and the memory itself lie outside the block.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation flag is clear and `rsp_valid` is 0, so a store-exclusive issued before any load-exclusive returns status 0 with no write.
- R2: A load-exclusive arms the flag and records `ld_ex_addr` as the tag. A following store-exclusive to that word drives `mem_we`=1, `mem_addr`=`sx_base`+`sx_offset`, `mem_wdata`=`sx_data` and `sx_status`=1, all in the request cycle.
- R3: A valid store on any snoop port whose word address equals the tag clears the flag. Snoop port k uses bits [k*ADDR_W +: ADDR_W] of `snoop_addr` and bit k of `snoop_valid`.
- R4: An ordinary local store (`st_valid`) to the tagged word clears the flag.
- R5: Tags are compared per 2**GRAN_LSB-byte word: address bits below GRAN_LSB (bits [1:0] by default) are ignored, and stores to any other word leave the flag armed.
- R6: A store-exclusive while the flag is clear drives `mem_we`=0 and `sx_status`=0.
- R7: A store-exclusive whose target word differs from the tag fails with status 0 and no write, even with the flag armed.
- R8: Every store-exclusive clears the flag, so a second store-exclusive without a new load-exclusive fails.
- R9: A snooped or local store to the tagged word in the same cycle as a store-exclusive makes that store-exclusive fail.
- R10: A load-exclusive always leaves the flag armed with its own tag, even when a clearing store or a store-exclusive arrives in the same cycle, and it replaces any earlier tag.
- R11: One cycle after each store-exclusive, `rsp_valid`=1 and `rsp_status` equals that request's `sx_status`. In cycles after no store-exclusive, `rsp_valid`=0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_ex_valid | input | 1 | Load-exclusive issued this cycle |
| ld_ex_addr | input | ADDR_W | Byte address of the load-exclusive |
| st_valid | input | 1 | Ordinary local store issued this cycle |
| st_addr | input | ADDR_W | Byte address of the local store |
| sx_valid | input | 1 | Store-exclusive issued this cycle |
| sx_base | input | ADDR_W | Base register of the store-exclusive |
| sx_offset | input | ADDR_W | Offset added to the base |
| sx_data | input | DATA_W | Register data to be written |
| snoop_valid | input | SNOOP_N | Per-port valid of snooped stores from other cores |
| snoop_addr | input | SNOOP_N*ADDR_W | Packed byte addresses of snooped stores |
| mem_we | output | 1 | Memory write enable for a successful store-exclusive |
| mem_addr | output | ADDR_W | Store-exclusive target address (base plus offset) |
| mem_wdata | output | DATA_W | Store-exclusive write data |
| sx_status | output | 1 | Same-cycle status: 1 success, 0 failure |
| rsp_valid | output | 1 | Registered status response valid |
| rsp_status | output | 1 | Registered status value |

## Verification
The bench builds the monitor with two snoop ports, 32-bit addresses and data, and word granularity (GRAN_LSB of 2). Two ports let it show that a hit on the second packed slice kills a reservation as surely as a hit on the first. Word granularity lets it use byte offsets inside the tagged word, which must still match, next to neighbouring words, which must not. A behavioural model of the flag and tag predicts every output each cycle. That includes the same-cycle collisions between a store-exclusive, a snoop, a local store and a new load-exclusive.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

   typedef enum logic {
      SX_FAIL = 1'b0,
      SX_PASS = 1'b1
   } sx_result_e;

   // Next-state request applied to the reservation entry
   typedef enum logic [1:0] {
      ENT_HOLD  = 2'd0,
      ENT_ARM   = 2'd1,
      ENT_CLEAR = 2'd2
   } ent_op_e;

endpackage

// File: rtl/excl_tag_cmp.sv
module excl_tag_cmp #(
   parameter int ADDR_W   = 32,
   parameter int GRAN_LSB = 2,
   localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TAG_W-1:0]  tag,
   output logic              hit
);

   generate
      if (GRAN_LSB == 0) begin : g_byte
         assign hit = req_valid && (req_addr == tag);
      end else begin : g_word
         logic unused_low_bits;
         assign unused_low_bits = ^req_addr[GRAN_LSB-1:0];
         assign hit = req_valid && (req_addr[ADDR_W-1:GRAN_LSB] == tag);
      end
   endgenerate

endmodule

// File: rtl/excl_entry.sv
module excl_entry
   import excl_mon_pkg::*;
#(
   parameter int TAG_W = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ent_op_e          op,
   input  logic [TAG_W-1:0] arm_tag,
   output logic [TAG_W-1:0] tag_q,
   output logic             flag_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         tag_q  <= '0;
      end else begin
         unique case (op)
            ENT_ARM: begin
               flag_q <= 1'b1;
               tag_q  <= arm_tag;
            end
            ENT_CLEAR: flag_q <= 1'b0;
            default:   flag_q <= flag_q;
         endcase
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !flag_q);

   assert_arm_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == ENT_ARM) |=> (flag_q && tag_q == $past(arm_tag)));

   assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == ENT_CLEAR) |=> !flag_q);

endmodule

// File: rtl/excl_rsp_reg.sv
module excl_rsp_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_status,
   output logic rsp_valid,
   output logic rsp_status
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_status <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_status <= req_valid & req_status;
      end
   end

   assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_valid && rsp_status == $past(req_status)));

   assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
   import excl_mon_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int GRAN_LSB = 2,
   parameter int SNOOP_N  = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld_ex_valid,
   input  logic [ADDR_W-1:0]         ld_ex_addr,
   input  logic                      st_valid,
   input  logic [ADDR_W-1:0]         st_addr,
   input  logic                      sx_valid,
   input  logic [ADDR_W-1:0]         sx_base,
   input  logic [ADDR_W-1:0]         sx_offset,
   input  logic [DATA_W-1:0]         sx_data,
   input  logic [SNOOP_N-1:0]        snoop_valid,
   input  logic [SNOOP_N*ADDR_W-1:0] snoop_addr,
   output logic                      mem_we,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic [DATA_W-1:0]         mem_wdata,
   output logic                      sx_status,
   output logic                      rsp_valid,
   output logic                      rsp_status
);

   localparam int TAG_W = ADDR_W - GRAN_LSB;

   generate
      if (GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad_gran
         $error("excl_monitor: GRAN_LSB must lie in [0, ADDR_W)");
      end
      if (SNOOP_N < 1) begin : g_bad_snoop
         $error("excl_monitor: SNOOP_N must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("excl_monitor: DATA_W must be at least 1");
      end
   endgenerate

   logic [TAG_W-1:0]   tag_q;
   logic               flag_q;
   logic [TAG_W-1:0]   ld_tag;
   logic [SNOOP_N-1:0] snoop_hit;
   logic               st_hit;
   logic               sx_hit;
   logic               kill;
   sx_result_e         result;
   ent_op_e            ent_op;

   assign mem_addr  = sx_base + sx_offset;
   assign mem_wdata = sx_data;
   assign ld_tag    = ld_ex_addr[ADDR_W-1:GRAN_LSB];

   generate
      for (genvar k = 0; k < SNOOP_N; k++) begin : g_snoop
         excl_tag_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_cmp (
            .req_valid (snoop_valid[k]),
            .req_addr  (snoop_addr[k*ADDR_W +: ADDR_W]),
            .tag       (tag_q),
            .hit       (snoop_hit[k])
         );
      end
   endgenerate

   excl_tag_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_st_cmp (
      .req_valid (st_valid),
      .req_addr  (st_addr),
      .tag       (tag_q),
      .hit       (st_hit)
   );

   excl_tag_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_sx_cmp (
      .req_valid (sx_valid),
      .req_addr  (mem_addr),
      .tag       (tag_q),
      .hit       (sx_hit)
   );

   assign kill = (|snoop_hit) | st_hit;

   always_comb begin
      result = (flag_q && sx_hit && !kill) ? SX_PASS : SX_FAIL;
      if (ld_ex_valid)            ent_op = ENT_ARM;
      else if (kill || sx_valid)  ent_op = ENT_CLEAR;
      else                        ent_op = ENT_HOLD;
   end

   assign sx_status = sx_valid && (result == SX_PASS);
   assign mem_we    = sx_status;

   excl_entry #(.TAG_W(TAG_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (ent_op),
      .arm_tag (ld_tag),
      .tag_q   (tag_q),
      .flag_q  (flag_q)
   );

   excl_rsp_reg u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (sx_valid),
      .req_status (sx_status),
      .rsp_valid  (rsp_valid),
      .rsp_status (rsp_status)
   );

   assert_we_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> flag_q);

   assert_collision_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_valid && (|snoop_hit || st_hit)) |-> !mem_we);

   assert_snoop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|snoop_hit) && !ld_ex_valid) |=> !flag_q);

   assert_local_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_hit && !ld_ex_valid) |=> !flag_q);

   assert_mismatch_fails_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_valid && !sx_hit) |-> !sx_status);

endmodule

// File: tb/excl_monitor_test.sv
module excl_monitor_test;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int SN = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ld_ex_valid, st_valid, sx_valid;
   logic [AW-1:0] ld_ex_addr, st_addr, sx_base, sx_offset;
   logic [DW-1:0] sx_data;
   logic [SN-1:0] snoop_valid;
   logic [SN*AW-1:0] snoop_addr;
   logic          mem_we, sx_status, rsp_valid, rsp_status;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // behavioural reference state
   bit        m_flag = 0;
   bit [29:0] m_tag  = '0;
   bit        m_rsp_v = 0;
   bit        m_rsp_s = 0;

   always #4 clk = ~clk;

   excl_monitor #(.ADDR_W(AW), .DATA_W(DW), .GRAN_LSB(2), .SNOOP_N(SN)) uut (
      .clk(clk), .rst_n(rst_n),
      .ld_ex_valid(ld_ex_valid), .ld_ex_addr(ld_ex_addr),
      .st_valid(st_valid), .st_addr(st_addr),
      .sx_valid(sx_valid), .sx_base(sx_base), .sx_offset(sx_offset), .sx_data(sx_data),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .sx_status(sx_status), .rsp_valid(rsp_valid), .rsp_status(rsp_status)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input string req,
                      input bit ldv, input bit [31:0] lda,
                      input bit stv, input bit [31:0] sta,
                      input bit sxv, input bit [31:0] sxb, input bit [31:0] sxo, input bit [31:0] sxd,
                      input bit [1:0] snv, input bit [31:0] sn0, input bit [31:0] sn1);
      bit [31:0] tgt;
      bit kill, pass;
      ld_ex_valid = ldv; ld_ex_addr = lda;
      st_valid = stv;    st_addr = sta;
      sx_valid = sxv;    sx_base = sxb; sx_offset = sxo; sx_data = sxd;
      snoop_valid = snv; snoop_addr = {sn1, sn0};
      tgt  = sxb + sxo;
      kill = (stv && sta[31:2] == m_tag) || (snv[0] && sn0[31:2] == m_tag)
             || (snv[1] && sn1[31:2] == m_tag);
      pass = sxv && m_flag && (tgt[31:2] == m_tag) && !kill;
      #2;
      check(req, "sx_status", {31'd0, sx_status}, {31'd0, pass});
      check(req, "mem_we", {31'd0, mem_we}, {31'd0, pass});
      if (pass) begin
         check(req, "mem_addr", mem_addr, tgt);
         check(req, "mem_wdata", mem_wdata, sxd);
      end
      check("R11", "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rsp_v});
      if (m_rsp_v) check("R11", "rsp_status", {31'd0, rsp_status}, {31'd0, m_rsp_s});
      @(posedge clk);
      m_rsp_v = sxv;
      m_rsp_s = pass;
      if (ldv) begin
         m_flag = 1;
         m_tag  = lda[31:2];
      end else if (kill || sxv) begin
         m_flag = 0;
      end
      @(negedge clk);
   endtask

   task automatic idle(input string req);
      cyc(req, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
   endtask
   task automatic ldex(input string req, input bit [31:0] a);
      cyc(req, 1, a, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0);
   endtask
   task automatic stex(input string req, input bit [31:0] b, input bit [31:0] o, input bit [31:0] d);
      cyc(req, 0, 0, 0, 0, 1, b, o, d, 2'b00, 0, 0);
   endtask

   initial begin
      rst_n = 0;
      ld_ex_valid = 0; st_valid = 0; sx_valid = 0;
      ld_ex_addr = 0; st_addr = 0; sx_base = 0; sx_offset = 0; sx_data = 0;
      snoop_valid = 0; snoop_addr = 0;
      repeat (3) @(negedge clk);
      check("R1", "rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1;
      // R1 / R6: store-exclusive before any reservation
      stex("R1", 32'h100, 0, 32'hDEAD0001);
      stex("R6", 32'h100, 0, 32'hDEAD0002);
      // R2: reserve then succeed, base plus offset
      ldex("R2", 32'h1000);
      stex("R2", 32'h0FFC, 32'h4, 32'hCAFE0001);
      // R8: second attempt without a new reservation
      stex("R8", 32'h1000, 0, 32'hCAFE0002);
      // R3: snoop on port 1 at a byte inside the word
      ldex("R3", 32'h2000);
      cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 32'h0, 32'h2003);
      stex("R3", 32'h2000, 0, 32'h11);
      // R3: snoop on port 0
      ldex("R3", 32'h2100);
      cyc("R3", 0, 0, 0, 0, 0, 0, 0, 0, 2'b01, 32'h2100, 32'h0);
      stex("R3", 32'h2100, 0, 32'h12);
      // R5: neighbouring words untouched, low bits ignored
      ldex("R5", 32'h3002);
      cyc("R5", 0, 0, 1, 32'h3004, 0, 0, 0, 0, 2'b11, 32'h2FFC, 32'h3008);
      stex("R5", 32'h3000, 32'h3, 32'h22);
      // R4: own ordinary store breaks reservation
      ldex("R4", 32'h4000);
      cyc("R4", 0, 0, 1, 32'h4001, 0, 0, 0, 0, 2'b00, 0, 0);
      stex("R4", 32'h4000, 0, 32'h33);
      // R7: wrong word fails, and the attempt still clears (R8)
      ldex("R7", 32'h5000);
      stex("R7", 32'h5004, 0, 32'h44);
      stex("R8", 32'h5000, 0, 32'h45);
      // R9: same-cycle snoop collision
      ldex("R9", 32'h6000);
      cyc("R9", 0, 0, 0, 0, 1, 32'h6000, 0, 32'h55, 2'b01, 32'h6002, 0);
      // R9: same-cycle local store collision
      ldex("R9", 32'h6100);
      cyc("R9", 0, 0, 1, 32'h6100, 1, 32'h6100, 0, 32'h56, 2'b00, 0, 0);
      // R10: reservation wins over same-cycle clearing store
      ldex("R10", 32'h7000);
      cyc("R10", 1, 32'h7000, 0, 0, 0, 0, 0, 0, 2'b01, 32'h7000, 0);
      stex("R10", 32'h7000, 0, 32'h66);
      // R10: overwrite tag
      ldex("R10", 32'h8000);
      ldex("R10", 32'h9000);
      stex("R10", 32'h9000, 0, 32'h77);
      // R10: reservation alongside a store-exclusive
      ldex("R10", 32'hA000);
      cyc("R10", 1, 32'hB000, 0, 0, 1, 32'hA000, 0, 32'h88, 2'b00, 0, 0);
      stex("R10", 32'hB000, 0, 32'h89);
      idle("R11");
      idle("R11");
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule